// File: doc/BRIEF.md
# Register-Mapped SPI Master Controller

This block is a serial peripheral interface master with a small register bus in front of it. Software pushes 8-bit words into a transmit queue, releases them, and collects the words clocked back on MISO from a receive queue. Every word is shifted MSB first over SCLK and MOSI. Clock polarity and phase come from control bits. The SCLK rate is fixed when the block is built, through a divider parameter.

A transmit-inhibit bit holds the shifter, so software can fill the queue and then let the whole burst run without gaps in the driver. The select lines come from a software-written, active-low select register. In automatic mode they are driven only while words are moving. In manual mode they follow the register for as long as the core is enabled. Three single-cycle event outputs report a drained transmit queue, a dropped transmit write and a dropped receive word.

Top module: `spi_ctl`

## Requirements
- R1: After reset the control register reads 0x0100 (only inhibit set) and the status register reads 0x05. All select lines are high, SCLK is low and no event output is high.
- R2: The register addresses are: control at 0, status at 1, transmit data at 2, receive data at 3 and select at 4. In the control register, bit 1 is enable, bit 2 is master, bit 3 is CPOL, bit 4 is CPHA, bit 7 is manual select and bit 8 is inhibit. These bits read back as written.
- R3: The status register reads receive-empty at bit 0, receive-full at bit 1, transmit-empty at bit 2 and transmit-full at bit 3. Bit 4 (mode fault) reads 0.
- R4: Writing control with bit 5 set empties the transmit queue, and writing control with bit 6 set empties the receive queue. Neither bit is stored: both read back as 0.
- R5: While inhibit is set, no word starts shifting, even when the transmit queue holds data.
- R6: A word spans 16 SCLK edges, spaced CLK_DIV clock cycles apart, and carries 8 bits MSB first. SCLK rests at the CPOL level when idle. With CPHA 0, data is sampled on the first edge of each bit; with CPHA 1, on the second.
- R7: Each completed word is pushed into the receive queue. Reading receive data pops the words in arrival order.
- R8: In automatic mode the select lines equal the select register while a burst runs and are all high otherwise. In manual mode they equal the select register while the core is enabled.
- R9: A write to a full transmit queue is dropped and pulses evt_tx_drop for one cycle.
- R10: A word completing while the receive queue is full is dropped and pulses evt_rx_drop. The words already held are kept.
- R11: evt_tx_empty pulses once when the last queued word has finished shifting.
- R12: Unless both enable and master are set, no word shifts and all select lines stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after bus_rd |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NSEL | Active-low slave selects |
| evt_tx_empty | output | 1 | Transmit queue drained pulse |
| evt_tx_drop | output | 1 | Transmit write dropped pulse |
| evt_rx_drop | output | 1 | Receive word dropped pulse |

## Verification
The bound assertions check several rules on every cycle. Drop events only occur when the queue concerned was full. An inhibited idle shifter stays idle. A disabled core leaves all selects high. An idle SCLK sits at the CPOL level. The drained-queue event only follows an empty transmit queue. The bench's scenarios are needed to show the rest: bit order and the sample edge in all four modes (checked through a MOSI-to-MISO loopback and an edge-accurate MOSI capture), receive ordering, exactly one drained event per burst, queue resets, and the manual versus automatic select behaviour.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_STAT = 3'd1;
  localparam logic [2:0] A_TXD  = 3'd2;
  localparam logic [2:0] A_RXD  = 3'd3;
  localparam logic [2:0] A_SEL  = 3'd4;

  localparam int B_EN   = 1;
  localparam int B_MST  = 2;
  localparam int B_CPOL = 3;
  localparam int B_CPHA = 4;
  localparam int B_TCLR = 5;
  localparam int B_RCLR = 6;
  localparam int B_MAN  = 7;
  localparam int B_INH  = 8;

  typedef struct packed {
    logic inh;
    logic man;
    logic cpha;
    logic cpol;
    logic mst;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/spi_ctl_fifo.sv
module spi_ctl_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] level;
  logic          push_ok, pop_ok;

  assign full    = (level == CW'(DEPTH));
  assign empty   = (level == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign rdata   = mem[rd_ptr];

  // storage without reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      if (push_ok && !pop_ok)      level <= level + 1'b1;
      else if (pop_ok && !push_ok) level <= level - 1'b1;
    end
  end
endmodule

// File: rtl/spi_ctl_shift.sv
module spi_ctl_shift #(
  parameter int W       = 8,
  parameter int CLK_DIV = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cpol,
  input  logic         cpha,
  input  logic         start,
  input  logic [W-1:0] tx_word,
  input  logic         miso,
  output logic         busy,
  output logic         sclk,
  output logic         mosi,
  output logic         done,
  output logic [W-1:0] rx_word
);
  localparam int DW    = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int EDGES = 2 * W;
  localparam int EW    = $clog2(EDGES);

  logic [DW-1:0] cnt;
  logic [EW-1:0] edge_n;
  logic [W-1:0]  tx_sr, rx_sr;
  logic          tick, lead, sample, last;

  always_comb begin
    tick   = (cnt == DW'(CLK_DIV - 1));
    lead   = !edge_n[0];
    sample = lead ^ cpha;
    last   = (edge_n == EW'(EDGES - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      sclk    <= 1'b0;
      mosi    <= 1'b0;
      done    <= 1'b0;
      rx_word <= '0;
      cnt     <= '0;
      edge_n  <= '0;
      tx_sr   <= '0;
      rx_sr   <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        sclk <= cpol;
        if (start) begin
          busy   <= 1'b1;
          cnt    <= '0;
          edge_n <= '0;
          if (!cpha) begin
            mosi  <= tx_word[W-1];
            tx_sr <= {tx_word[W-2:0], 1'b0};
          end else begin
            tx_sr <= tx_word;
          end
        end
      end else if (tick) begin
        cnt    <= '0;
        sclk   <= ~sclk;
        edge_n <= edge_n + 1'b1;
        if (sample) begin
          rx_sr <= {rx_sr[W-2:0], miso};
        end else if (!last) begin
          mosi  <= tx_sr[W-1];
          tx_sr <= {tx_sr[W-2:0], 1'b0};
        end
        if (last) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          rx_word <= sample ? {rx_sr[W-2:0], miso} : rx_sr;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_ctl.sv
module spi_ctl
  import spi_ctl_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int CLK_DIV = 2,
  parameter int NSEL    = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [2:0]      bus_addr,
  input  logic [15:0]     bus_wdata,
  output logic [15:0]     bus_rdata,
  output logic            sclk,
  output logic            mosi,
  input  logic            miso,
  output logic [NSEL-1:0] ss_n,
  output logic            evt_tx_empty,
  output logic            evt_tx_drop,
  output logic            evt_rx_drop
);
  localparam int W = 8;

  ctrl_t           ctrl_q;
  logic [NSEL-1:0] sel_q;
  logic            wr_ctrl, tx_clr, rx_clr, tx_push, rx_pop, start;
  logic            tx_empty, tx_full, rx_empty, rx_full;
  logic            busy, done;
  logic [W-1:0]    tx_head, rx_head, rx_word;
  logic [15:0]     rd_mux;
  logic            unused_wbits;

  assign unused_wbits = ^{bus_wdata[15:9], bus_wdata[0]};
  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign tx_clr  = wr_ctrl && bus_wdata[B_TCLR];
  assign rx_clr  = wr_ctrl && bus_wdata[B_RCLR];
  assign tx_push = bus_wr && (bus_addr == A_TXD);
  assign rx_pop  = bus_rd && (bus_addr == A_RXD);
  assign start   = ctrl_q.en && ctrl_q.mst && !ctrl_q.inh && !busy && !tx_empty;

  spi_ctl_fifo #(.W(W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .clr(tx_clr), .push(tx_push), .wdata(bus_wdata[W-1:0]),
    .pop(start), .rdata(tx_head), .empty(tx_empty), .full(tx_full));

  spi_ctl_fifo #(.W(W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .clr(rx_clr), .push(done), .wdata(rx_word),
    .pop(rx_pop), .rdata(rx_head), .empty(rx_empty), .full(rx_full));

  spi_ctl_shift #(.W(W), .CLK_DIV(CLK_DIV)) u_shift (
    .clk(clk), .rst(rst), .cpol(ctrl_q.cpol), .cpha(ctrl_q.cpha), .start(start),
    .tx_word(tx_head), .miso(miso), .busy(busy), .sclk(sclk), .mosi(mosi),
    .done(done), .rx_word(rx_word));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '{inh: 1'b1, default: 1'b0};
      sel_q  <= '1;
    end else if (bus_wr) begin
      if (bus_addr == A_CTRL) begin
        ctrl_q.en   <= bus_wdata[B_EN];
        ctrl_q.mst  <= bus_wdata[B_MST];
        ctrl_q.cpol <= bus_wdata[B_CPOL];
        ctrl_q.cpha <= bus_wdata[B_CPHA];
        ctrl_q.man  <= bus_wdata[B_MAN];
        ctrl_q.inh  <= bus_wdata[B_INH];
      end
      if (bus_addr == A_SEL) sel_q <= bus_wdata[NSEL-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_CTRL: begin
        rd_mux[B_EN]   = ctrl_q.en;
        rd_mux[B_MST]  = ctrl_q.mst;
        rd_mux[B_CPOL] = ctrl_q.cpol;
        rd_mux[B_CPHA] = ctrl_q.cpha;
        rd_mux[B_MAN]  = ctrl_q.man;
        rd_mux[B_INH]  = ctrl_q.inh;
      end
      A_STAT:  rd_mux[3:0] = {tx_full, tx_empty, rx_full, rx_empty};
      A_RXD:   rd_mux[W-1:0] = rx_head;
      A_SEL:   rd_mux[NSEL-1:0] = sel_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata    <= '0;
      ss_n         <= '1;
      evt_tx_empty <= 1'b0;
      evt_tx_drop  <= 1'b0;
      evt_rx_drop  <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_mux;
      ss_n         <= (ctrl_q.en && ctrl_q.mst && (ctrl_q.man || busy || start)) ? sel_q : '1;
      evt_tx_empty <= done && tx_empty;
      evt_tx_drop  <= tx_push && tx_full && !tx_clr;
      evt_rx_drop  <= done && rx_full && !rx_clr;
    end
  end
endmodule

// File: rtl/spi_ctl_chk.sv
module spi_ctl_chk #(
  parameter int NSEL = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            en,
  input logic            mst,
  input logic            cpol,
  input logic            inh,
  input logic            busy,
  input logic            sclk,
  input logic [NSEL-1:0] ss_n,
  input logic            tx_full,
  input logic            tx_empty,
  input logic            rx_full,
  input logic            evt_tx_empty,
  input logic            evt_tx_drop,
  input logic            evt_rx_drop
);
  assert_tx_drop_R9: assert property (@(posedge clk) disable iff (rst)
    evt_tx_drop |-> $past(tx_full));

  assert_rx_drop_R10: assert property (@(posedge clk) disable iff (rst)
    evt_rx_drop |-> $past(rx_full));

  assert_inhibit_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (inh && !busy) |=> !busy);

  assert_gate_sel_R12: assert property (@(posedge clk) disable iff (rst)
    !(en && mst) |=> (ss_n == '1));

  assert_sclk_rest_R6: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy) && $stable(cpol)) |-> (sclk == cpol));

  assert_drain_evt_R11: assert property (@(posedge clk) disable iff (rst)
    evt_tx_empty |-> $past(tx_empty));
endmodule

bind spi_ctl spi_ctl_chk #(.NSEL(NSEL)) u_chk (
  .clk(clk), .rst(rst), .en(ctrl_q.en), .mst(ctrl_q.mst), .cpol(ctrl_q.cpol),
  .inh(ctrl_q.inh), .busy(busy), .sclk(sclk), .ss_n(ss_n), .tx_full(tx_full),
  .tx_empty(tx_empty), .rx_full(rx_full), .evt_tx_empty(evt_tx_empty),
  .evt_tx_drop(evt_tx_drop), .evt_rx_drop(evt_rx_drop));

// File: tb/spi_ctl_test.sv
module spi_ctl_test;
  localparam int DEPTH = 16;
  localparam int DIV   = 2;
  localparam int NSEL  = 4;

  logic            clk = 0, rst = 1;
  logic            bus_wr = 0, bus_rd = 0;
  logic [2:0]      bus_addr = '0;
  logic [15:0]     bus_wdata = '0, bus_rdata;
  logic            sclk, mosi, miso, inv = 0;
  logic [NSEL-1:0] ss_n;
  logic            evt_tx_empty, evt_tx_drop, evt_rx_drop;

  assign miso = mosi ^ inv;

  spi_ctl #(.DEPTH(DEPTH), .CLK_DIV(DIV), .NSEL(NSEL)) uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi), .miso(miso),
    .ss_n(ss_n), .evt_tx_empty(evt_tx_empty), .evt_tx_drop(evt_tx_drop),
    .evt_rx_drop(evt_rx_drop));

  always #2 clk = ~clk;

  int checks = 0, errors = 0, finished = 0;
  int n_txe = 0, n_txd = 0, n_rxd = 0, edges = 0, bits = 0, cpol_age = 0;
  logic m_cpol = 0, m_cpha = 0, sclk_prev = 0;
  logic [NSEL-1:0] m_sel = '1;
  logic [7:0] cap = 0;
  logic [7:0] exp_q[$];
  logic [7:0] cap_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference, compared each clock
  always @(negedge clk) begin
    if (!rst) begin
      n_txe += int'(evt_tx_empty);
      n_txd += int'(evt_tx_drop);
      n_rxd += int'(evt_rx_drop);
      cpol_age++;
      chk(ss_n == '1 || ss_n == m_sel, "R8 ss_n value", int'(ss_n), int'(m_sel));
      if (ss_n == '1 && cpol_age > 3)
        chk(sclk == m_cpol, "R6 idle sclk", int'(sclk), int'(m_cpol));
      if (ss_n != '1 && sclk != sclk_prev) begin
        edges++;
        if (sclk == (m_cpol == m_cpha)) begin
          cap = {cap[6:0], mosi};
          bits++;
          if (bits == 8) begin
            cap_q.push_back(cap);
            bits = 0;
          end
        end
      end
    end
    sclk_prev = sclk;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    if (a == 3'd0) begin m_cpol = d[3]; m_cpha = d[4]; cpol_age = 0; end
    if (a == 3'd4) m_sel = d[NSEL-1:0];
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic push_tx(input logic [7:0] b);
    wr(3'd2, {8'h00, b});
    exp_q.push_back(b);
  endtask

  task automatic run_burst(input logic [15:0] c, input int n);
    wr(3'd0, c & ~16'h0100);
    idle(6);
    chk(ss_n == m_sel, "R8 auto select during burst", int'(ss_n), int'(m_sel));
    idle(n * (16 * DIV + 4) + 10);
    wr(3'd0, c | 16'h0100);
  endtask

  task automatic check_burst(input int nrx);
    logic [15:0] d;
    chk(cap_q.size() == exp_q.size(), "R6 word count", cap_q.size(), exp_q.size());
    chk(edges == 16 * exp_q.size(), "R6 sclk edges", edges, 16 * exp_q.size());
    for (int i = 0; i < exp_q.size() && i < cap_q.size(); i++)
      chk(cap_q[i] == exp_q[i], "R6 mosi msb-first", int'(cap_q[i]), int'(exp_q[i]));
    for (int i = 0; i < nrx; i++) begin
      rd(3'd3, d);
      chk(d == {8'h00, exp_q[i] ^ {8{inv}}}, "R7 rx order", int'(d), int'(exp_q[i] ^ {8{inv}}));
    end
    exp_q.delete(); cap_q.delete(); edges = 0;
  endtask

  initial begin
    logic [15:0] d;
    int k;
    repeat (3) @(negedge clk);
    rst = 0;
    idle(2);
    chk(ss_n == '1 && sclk == 0, "R1 reset pins", int'({ss_n, sclk}), 'h1e);
    chk(!evt_tx_empty && !evt_tx_drop && !evt_rx_drop, "R1 events", 1, 0);
    rd(3'd0, d); chk(d == 16'h0100, "R1 ctrl reset", d, 'h0100);
    rd(3'd1, d); chk(d == 16'h0005, "R1 status reset", d, 'h05);

    // basic burst, mode 0
    wr(3'd0, 16'h0106);
    rd(3'd0, d); chk(d == 16'h0106, "R2 ctrl readback", d, 'h0106);
    wr(3'd4, 16'h000B);
    rd(3'd4, d); chk(d == 16'h000B, "R2 sel readback", d, 'hB);
    push_tx(8'hA5); push_tx(8'h3C);
    rd(3'd1, d); chk(d == 16'h0001, "R3 tx pending status", d, 'h01);
    idle(60);
    chk(cap_q.size() == 0 && edges == 0, "R5 inhibit holds", edges, 0);
    rd(3'd1, d); chk(d == 16'h0001, "R5 queue kept", d, 'h01);
    k = n_txe;
    run_burst(16'h0106, 2);
    chk(n_txe - k == 1, "R11 one drain pulse", n_txe - k, 1);
    chk(ss_n == '1, "R8 auto idle deselect", int'(ss_n), 'hf);
    check_burst(2);
    rd(3'd1, d); chk(d == 16'h0005, "R3 empty after read", d, 'h05);

    // all four modes, loopback inverted on odd modes
    for (int m = 0; m < 4; m++) begin
      logic [15:0] c;
      c = 16'h0106 | 16'(m[0]) << 3 | 16'(m[1]) << 4;
      inv = m[0];
      wr(3'd0, c);
      idle(5);
      chk(sclk == m[0], "R6 rest level", int'(sclk), m[0]);
      push_tx(8'h5A + 8'(m * 37)); push_tx(8'h81 ^ 8'(m));
      run_burst(c, 2);
      check_burst(2);
    end
    inv = 0;
    wr(3'd0, 16'h0106);

    // manual select
    wr(3'd4, 16'h0007);
    wr(3'd0, 16'h0186);
    idle(3);
    chk(ss_n == 4'h7, "R8 manual select", int'(ss_n), 'h7);
    wr(3'd0, 16'h0106);
    idle(3);
    chk(ss_n == 4'hF, "R8 auto idle", int'(ss_n), 'hf);

    // fifo resets
    push_tx(8'h11); push_tx(8'h22); push_tx(8'h33);
    wr(3'd0, 16'h0126);
    rd(3'd1, d); chk(d == 16'h0005, "R4 tx reset", d, 'h05);
    rd(3'd0, d); chk(d == 16'h0106, "R4 reset bit not stored", d, 'h0106);
    exp_q.delete();
    push_tx(8'h44); push_tx(8'h55);
    run_burst(16'h0106, 2);
    rd(3'd1, d); chk(d == 16'h0004, "R3 rx pending status", d, 'h04);
    wr(3'd0, 16'h0146);
    rd(3'd1, d); chk(d == 16'h0005, "R4 rx reset", d, 'h05);
    exp_q.delete(); cap_q.delete(); edges = 0;

    // transmit overflow then receive overflow
    for (int i = 0; i < DEPTH; i++) push_tx(8'(i * 13 + 7));
    rd(3'd1, d); chk(d == 16'h0009, "R3 tx full status", d, 'h09);
    k = n_txd;
    wr(3'd2, 16'h00FF);
    idle(2);
    chk(n_txd - k == 1, "R9 drop pulse", n_txd - k, 1);
    run_burst(16'h0106, DEPTH);
    rd(3'd1, d); chk(d == 16'h0006, "R3 rx full status", d, 'h06);
    k = n_rxd;
    push_tx(8'hEE);
    run_burst(16'h0106, 1);
    chk(n_rxd - k == 1, "R10 overrun pulse", n_rxd - k, 1);
    check_burst(DEPTH);
    rd(3'd1, d); chk(d == 16'h0005, "R10 dropped word absent", d, 'h05);

    // enable / master gating
    wr(3'd0, 16'h0004);
    wr(3'd2, 16'h0077);
    idle(60);
    chk(ss_n == '1 && edges == 0, "R12 no master without enable", edges, 0);
    wr(3'd0, 16'h0002);
    idle(60);
    chk(ss_n == '1 && edges == 0, "R12 no enable without master", edges, 0);
    rd(3'd1, d); chk(d == 16'h0001, "R12 word still queued", d, 'h01);
    wr(3'd0, 16'h0126);
    rd(3'd1, d); chk(d == 16'h0005, "R4 cleared", d, 'h05);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (finished == 0) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule